// File: doc/BRIEF.md
# PLL Divider Search Unit

This block works out a set of divider settings for a phase-locked loop fed by a fixed 24000 kHz reference. Given a wanted output frequency in kHz, it first picks the two output dividers so that the oscillator (VCO) runs at or above its lower limit. It then tries each input divider from 1 to 62 in turn and, for each, rounds the feedback divider to the nearest whole value. It keeps the setting with the smallest frequency error and reports either a usable result or an error.

A pulse on `start` loads the target and raises `busy`. All quotients come from one shared shift-subtract divider inside the block, which takes 22 cycles per quotient. `done` then pulses for one cycle. With it come `ok` or `err` and the four divider fields, which hold their values until the next search completes. A search whose first candidate is exact takes about 75 cycles. A search that tries every input divider takes about 3000 cycles.

The controller moves through these states:
- S_IDLE goes to S_P1 on `start`, or straight to S_END for a target that is out of range.
- S_P1 waits for the first output-divider quotient. It goes to S_P2 if that quotient is above 7, otherwise to S_CHK.
- S_P2 waits for the second output divider. It goes to S_END if that divider is above 7, otherwise to S_P1B.
- S_P1B waits for the recomputed first divider, then goes to S_CHK.
- S_CHK forms the VCO and goes to S_END if the VCO is out of range, otherwise to S_REF.
- S_REF waits for the reference step and goes to S_FB.
- S_FB waits for the feedback quotient and remainder and goes to S_EVAL.
- S_EVAL scores the candidate. It goes back to S_REF, or to S_END after input divider 62 or once the error is zero.
- S_END raises `done` and returns to S_IDLE.

Top module: `pll_div_search`

## Requirements
- R1: While reset is low and after it is released, `busy`, `done`, `ok` and `err` are 0 and all four divider outputs are 0, until the first search completes.
- R2: A target of 0, or a target above 2400000, ends the search with `err` = 1. For such a target, `done` is seen no later than 3 cycles after the clock edge that sampled `start`.
- R3: The first output divider starts as ceil(600000 / target). If that value is above 7, the second output divider becomes ceil(value / 7) and the first becomes ceil(value / second). Example: target 12245 gives 7 and 7, and target 65000 gives 5 and 2.
- R4: If the second output divider would be above 7, the search fails. Examples: target 12244 and target 1.
- R5: The VCO is target × first divider × second divider. If the VCO lies outside 600000..2400000, the search fails. Example: 2400000 is accepted, with input divider 1 and feedback divider 100.
- R6: The input divider r runs from 1 to 62. The step is floor(24000 / r) and the feedback divider is floor(VCO / step). A candidate replaces the best only if its error is strictly smaller. Ties keep the lower r. The search ends early once the error is zero, so a target whose first candidate is exact (600000) completes within 200 cycles.
- R7: A candidate whose feedback divider is 16 or less, or 3200 or more, is skipped. If the remainder is more than half the step and divider + 1 < 3200, the divider is incremented and the error becomes step − remainder.
- R8: If the best error exceeds the error limit (parameter, 4000 kHz by default), the result is `err` = 1. With a limit of 0, any inexact target such as 33333 fails.
- R9: On `start` while idle, `busy` is 1 from the next cycle until completion. `done` is a single-cycle pulse with `busy` low. A `start` while busy is ignored.
- R10: `ok`, `err` and the divider outputs change only on the cycle `done` is high and then hold. Exactly one of `ok` and `err` is 1 at `done`. On failure all four divider outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search; sampled only while idle |
| target_khz | input | 32 | Wanted output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result usable |
| err | output | 1 | No acceptable setting |
| refdiv | output | 6 | Chosen input divider (0 on failure) |
| fbdiv | output | 12 | Chosen feedback divider (0 on failure) |
| postdiv1 | output | 3 | First output divider (0 on failure) |
| postdiv2 | output | 3 | Second output divider (0 on failure) |

## Verification
The assertions check the following on every cycle:
- the handshake: `done` is a single pulse with `busy` low, and `start` while idle raises `busy`;
- that results hold between completions and that `ok` and `err` are exclusive;
- that a successful result always lies within the legal divider windows.

Only the bench's scenarios can show that the chosen dividers are the best ones: that rounding, strict improvement, the skipping of out-of-window candidates and the error limit pick exactly the setting a behavioural search picks. The same applies to the early exit on an exact first candidate and to ignoring a mid-search `start`.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_P1,
        S_P2,
        S_P1B,
        S_CHK,
        S_REF,
        S_FB,
        S_EVAL,
        S_END
    } pds_state_t;

endpackage

// File: rtl/pds_divider.sv
// Unsigned restoring divider: one quotient bit per cycle, W cycles per result.
module pds_divider #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic          active;
    logic [W:0]    trial;
    logic [W:0]    diff;

    always_comb begin
        trial = {rem, quo[W-1]};
        diff  = trial - {1'b0, den};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo    <= '0;
            rem    <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                quo    <= num;
                rem    <= '0;
                cnt    <= CW'(W);
                active <= 1'b1;
            end else if (active) begin
                if (!diff[W]) begin
                    rem <= diff[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pds_eval.sv
// Scores one input-divider candidate: window test, nearest rounding, strict improvement.
module pds_eval #(
    parameter int W     = 22,
    parameter int FW    = 12,
    parameter int FB_HI = 3200,
    parameter int FB_LO = 16
) (
    input  logic [W-1:0]  quo,
    input  logic [W-1:0]  remv,
    input  logic [W-1:0]  fref,
    input  logic [W-1:0]  best,
    output logic          take,
    output logic [W-1:0]  diff,
    output logic [FW-1:0] fb
);
    logic          in_window;
    logic          bump;
    logic [W-1:0]  fb_adj;

    always_comb begin
        in_window = (quo < W'(FB_HI)) && (quo > W'(FB_LO));
        bump      = (quo < W'(FB_HI - 1)) && (remv > (fref >> 1));
        fb_adj    = bump ? quo + W'(1) : quo;
        diff      = bump ? fref - remv : remv;
        take      = in_window && (diff < best);
        fb        = fb_adj[FW-1:0];
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pds_pkg::*;
#(
    parameter int TW          = 32,
    parameter int DW          = 22,
    parameter int REF_KHZ     = 24000,
    parameter int VCO_MIN_KHZ = 600000,
    parameter int VCO_MAX_KHZ = 2400000,
    parameter int PD_MAX      = 7,
    parameter int RD_MAX      = 62,
    parameter int FB_HI       = 3200,
    parameter int FB_LO       = 16,
    parameter int ERR_LIM_KHZ = 4000,
    localparam int RW         = $clog2(RD_MAX + 1),
    localparam int FW         = $clog2(FB_HI),
    localparam int PW         = $clog2(PD_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] target_khz,
    output logic          busy,
    output logic          done,
    output logic          ok,
    output logic          err,
    output logic [RW-1:0] refdiv,
    output logic [FW-1:0] fbdiv,
    output logic [PW-1:0] postdiv1,
    output logic [PW-1:0] postdiv2
);
    localparam int VFW = DW + 2 * PW;

    pds_state_t state, nxt;

    logic [DW-1:0]  tgt, p1w, vco, fref, fbq, remq, best;
    logic [PW-1:0]  pd1, pd2;
    logic [RW-1:0]  rcur, best_r;
    logic [FW-1:0]  best_fb;
    logic           fail;
    logic           dgo;
    logic [DW-1:0]  dnum, dden, quo, rem;
    logic           fin;
    logic [VFW-1:0] vco_full;
    logic           vco_bad, bad_tgt, take, stop_search;
    logic [DW-1:0]  cdiff, best_nxt;
    logic [FW-1:0]  cfb;

    pds_divider #(.W(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dgo), .num(dnum), .den(dden),
        .quo(quo), .rem(rem), .fin(fin)
    );

    pds_eval #(.W(DW), .FW(FW), .FB_HI(FB_HI), .FB_LO(FB_LO)) u_eval (
        .quo(fbq), .remv(remq), .fref(fref), .best(best),
        .take(take), .diff(cdiff), .fb(cfb)
    );

    always_comb begin
        bad_tgt     = (target_khz == '0) || (target_khz > TW'(VCO_MAX_KHZ));
        vco_full    = VFW'(tgt) * VFW'(pd1) * VFW'(pd2);
        vco_bad     = (vco_full < VFW'(VCO_MIN_KHZ)) || (vco_full > VFW'(VCO_MAX_KHZ));
        best_nxt    = take ? cdiff : best;
        stop_search = (rcur == RW'(RD_MAX)) || (best_nxt == '0);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = bad_tgt ? S_END : S_P1;
            S_P1:    if (fin) nxt = (quo > DW'(PD_MAX)) ? S_P2 : S_CHK;
            S_P2:    if (fin) nxt = (quo > DW'(PD_MAX)) ? S_END : S_P1B;
            S_P1B:   if (fin) nxt = S_CHK;
            S_CHK:   nxt = vco_bad ? S_END : S_REF;
            S_REF:   if (fin) nxt = S_FB;
            S_FB:    if (fin) nxt = S_EVAL;
            S_EVAL:  nxt = stop_search ? S_END : S_REF;
            S_END:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;  done <= 1'b0;  ok <= 1'b0;  err <= 1'b0;
            refdiv <= '0;  fbdiv <= '0;   postdiv1 <= '0;  postdiv2 <= '0;
            tgt <= '0;  p1w <= '0;  vco <= '0;  fref <= '0;  fbq <= '0;
            remq <= '0;  best <= '0;  pd1 <= '0;  pd2 <= '0;  rcur <= '0;
            best_r <= '0;  best_fb <= '0;  fail <= 1'b0;
            dgo <= 1'b0;  dnum <= '0;  dden <= '0;
        end else begin
            dgo  <= 1'b0;
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    busy <= 1'b1;
                    tgt  <= target_khz[DW-1:0];
                    fail <= bad_tgt;
                    pd2  <= PW'(1);
                    dnum <= DW'(VCO_MIN_KHZ) + target_khz[DW-1:0] - DW'(1);
                    dden <= target_khz[DW-1:0];
                    dgo  <= !bad_tgt;
                end
                S_P1: if (fin) begin
                    p1w <= quo;
                    if (quo > DW'(PD_MAX)) begin
                        dnum <= quo + DW'(PD_MAX - 1);
                        dden <= DW'(PD_MAX);
                        dgo  <= 1'b1;
                    end else begin
                        pd1 <= quo[PW-1:0];
                    end
                end
                S_P2: if (fin) begin
                    pd2 <= quo[PW-1:0];
                    if (quo > DW'(PD_MAX)) begin
                        fail <= 1'b1;
                    end else begin
                        dnum <= p1w + quo - DW'(1);
                        dden <= quo;
                        dgo  <= 1'b1;
                    end
                end
                S_P1B: if (fin) pd1 <= quo[PW-1:0];
                S_CHK: begin
                    vco    <= vco_full[DW-1:0];
                    best   <= vco_full[DW-1:0];
                    rcur   <= RW'(1);
                    best_r <= '0;
                    if (vco_bad) begin
                        fail <= 1'b1;
                    end else begin
                        dnum <= DW'(REF_KHZ);
                        dden <= DW'(1);
                        dgo  <= 1'b1;
                    end
                end
                S_REF: if (fin) begin
                    fref <= quo;
                    dnum <= vco;
                    dden <= quo;
                    dgo  <= 1'b1;
                end
                S_FB: if (fin) begin
                    fbq  <= quo;
                    remq <= rem;
                end
                S_EVAL: begin
                    if (take) begin
                        best    <= cdiff;
                        best_r  <= rcur;
                        best_fb <= cfb;
                    end
                    if (!stop_search) begin
                        rcur <= rcur + RW'(1);
                        dnum <= DW'(REF_KHZ);
                        dden <= DW'(rcur) + DW'(1);
                        dgo  <= 1'b1;
                    end
                end
                S_END: begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (!fail && (best <= DW'(ERR_LIM_KHZ))) begin
                        ok <= 1'b1;  err <= 1'b0;
                        refdiv <= best_r;  fbdiv <= best_fb;
                        postdiv1 <= pd1;   postdiv2 <= pd2;
                    end else begin
                        ok <= 1'b0;  err <= 1'b1;
                        refdiv <= '0;  fbdiv <= '0;
                        postdiv1 <= '0;  postdiv2 <= '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
    parameter int RW     = 6,
    parameter int FW     = 12,
    parameter int PW     = 3,
    parameter int RD_MAX = 62,
    parameter int FB_HI  = 3200,
    parameter int FB_LO  = 16,
    parameter int PD_MAX = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          ok,
    input logic          err,
    input logic [RW-1:0] refdiv,
    input logic [FW-1:0] fbdiv,
    input logic [PW-1:0] postdiv1,
    input logic [PW-1:0] postdiv2
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({ok, err, refdiv, fbdiv, postdiv1, postdiv2}));
    // R10
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok ^ err));
    // R10
    fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (refdiv == '0 && fbdiv == '0 && postdiv1 == '0 && postdiv2 == '0));
    // R7
    fb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (fbdiv > FW'(FB_LO) && fbdiv < FW'(FB_HI)));
    // R6
    ref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (refdiv >= RW'(1) && refdiv <= RW'(RD_MAX)));
    // R3
    post_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (postdiv1 >= PW'(1) && postdiv1 <= PW'(PD_MAX) &&
                postdiv2 >= PW'(1) && postdiv2 <= PW'(PD_MAX)));
endmodule

bind pll_div_search pds_chk #(
    .RW(RW), .FW(FW), .PW(PW), .RD_MAX(RD_MAX),
    .FB_HI(FB_HI), .FB_LO(FB_LO), .PD_MAX(PD_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ok(ok), .err(err), .refdiv(refdiv), .fbdiv(fbdiv),
    .postdiv1(postdiv1), .postdiv2(postdiv2)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 10000;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_khz = '0;

    logic        busy0, done0, ok0, err0, busy1, done1, ok1, err1;
    logic [5:0]  rd0, rd1;
    logic [11:0] fb0, fb1;
    logic [2:0]  pa0, pb0, pa1, pb1;
    logic [25:0] res0, res1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;
    int lat;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cycles++;

    pll_div_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
        .busy(busy0), .done(done0), .ok(ok0), .err(err0),
        .refdiv(rd0), .fbdiv(fb0), .postdiv1(pa0), .postdiv2(pb0)
    );

    pll_div_search #(.ERR_LIM_KHZ(0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
        .busy(busy1), .done(done1), .ok(ok1), .err(err1),
        .refdiv(rd1), .fbdiv(fb1), .postdiv1(pa1), .postdiv2(pb1)
    );

    assign res0 = {ok0, err0, rd0, fb0, pa0, pb0};
    assign res1 = {ok1, err1, rd1, fb1, pa1, pb1};

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural search written from the requirements; packs {ok,err,r,fb,p1,p2}.
    function automatic logic [25:0] expect_vec(longint t, longint lim);
        longint a, b, v, best, fr, f, d, br, bf;
        logic [25:0] fail_vec;
        fail_vec = {1'b0, 1'b1, 24'd0};
        if (t == 0) return fail_vec;
        a = (600000 + t - 1) / t;
        b = 1;
        if (a > 7) begin
            b = (a + 6) / 7;
            a = (a + b - 1) / b;
        end
        if (b > 7) return fail_vec;
        v = t * a * b;
        if (v < 600000 || v > 2400000) return fail_vec;
        best = v; br = 0; bf = 0;
        for (int k = 1; k < 63 && best != 0; k++) begin
            fr = 24000 / k;
            f  = v / fr;
            if (f >= 3200 || f <= 16) continue;
            d = v - f * fr;
            if (f + 1 < 3200 && d > fr / 2) begin
                f = f + 1;
                d = fr - d;
            end
            if (d >= best) continue;
            best = d; br = k; bf = f;
        end
        if (best > lim) return fail_vec;
        return {1'b1, 1'b0, br[5:0], bf[11:0], a[2:0], b[2:0]};
    endfunction

    task automatic run(input longint t, input bit poke, input string req, output int latency);
        logic [25:0] want0, want1, held0, held1;
        bit seen0, seen1;
        int n;
        want0 = expect_vec(t, 4000);
        want1 = expect_vec(t, 0);
        held0 = res0;
        held1 = res1;
        latency = 0;
        @(negedge clk);
        start = 1'b1;
        target_khz = t[31:0];
        @(negedge clk);
        start = 1'b0;
        seen0 = 0; seen1 = 0; n = 0;
        while (!(seen0 && seen1) && n < RUN_LIMIT) begin
            n++;
            if (!seen0) begin
                if (done0) begin
                    seen0 = 1; latency = n;
                    chk(res0 == want0, req, "u0 result", res0, want0);
                end else begin
                    chk(busy0 == 1'b1, "R9", "u0 busy during search", busy0, 1);
                    chk(res0 == held0, "R10", "u0 hold during search", res0, held0);
                end
            end else begin
                chk(!busy0 && !done0 && res0 == want0, "R10", "u0 hold after done", res0, want0);
            end
            if (!seen1) begin
                if (done1) begin
                    seen1 = 1;
                    chk(res1 == want1, req, "u1 result", res1, want1);
                end else begin
                    chk(busy1 == 1'b1, "R9", "u1 busy during search", busy1, 1);
                    chk(res1 == held1, "R10", "u1 hold during search", res1, held1);
                end
            end else begin
                chk(!busy1 && !done1 && res1 == want1, "R10", "u1 hold after done", res1, want1);
            end
            if (poke && n == 10) begin
                start = 1'b1;
                target_khz = 32'd600000;
            end else if (poke && n == 11) begin
                start = 1'b0;
                target_khz = t[31:0];
            end
            @(negedge clk);
        end
        chk(seen0 && seen1, "R9", "completion within run limit", n, RUN_LIMIT);
        for (int i = 0; i < 3; i++) begin
            chk(!busy0 && !done0 && res0 == want0, "R10", "u0 idle hold", res0, want0);
            chk(!busy1 && !done1 && res1 == want1, "R10", "u1 idle hold", res1, want1);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        while (!finished && cycles < WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(!busy0 && !done0 && res0 == '0, "R1", "u0 during reset", res0, 0);
        chk(!busy1 && !done1 && res1 == '0, "R1", "u1 during reset", res1, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy0 && !done0 && res0 == '0, "R1", "u0 after reset", res0, 0);
        chk(!busy1 && !done1 && res1 == '0, "R1", "u1 after reset", res1, 0);

        run(600000, 0, "R6", lat);
        chk(lat <= 200, "R6", "early stop latency", lat, 200);
        chk(ok0 && rd0 == 6'd1 && fb0 == 12'd25, "R6", "exact first candidate", {rd0, fb0}, {6'd1, 12'd25});

        run(0, 0, "R2", lat);
        chk(lat <= 3 && err0, "R2", "zero target fast fail", lat, 3);
        run(2400001, 0, "R2", lat);
        chk(lat <= 3 && err0, "R2", "over-range target fast fail", lat, 3);

        run(2400000, 0, "R5", lat);
        chk(ok0 && rd0 == 6'd1 && fb0 == 12'd100, "R5", "top of VCO range", {rd0, fb0}, {6'd1, 12'd100});

        run(12245, 0, "R3", lat);
        chk(ok0 && pa0 == 3'd7 && pb0 == 3'd7, "R3", "post dividers 7/7", {pa0, pb0}, {3'd7, 3'd7});
        run(65000, 0, "R3", lat);
        chk(ok0 && pa0 == 3'd5 && pb0 == 3'd2, "R3", "post dividers 5/2", {pa0, pb0}, {3'd5, 3'd2});

        run(12244, 0, "R4", lat);
        chk(err0 == 1'b1, "R4", "second divider above 7", err0, 1);
        run(1, 0, "R4", lat);

        run(33333, 1, "R9", lat);
        chk(ok0 && err1, "R8", "error limit 0 rejects inexact", {ok0, err1}, 2'b11);

        run(1188000, 0, "R7", lat);
        run(148500, 0, "R7", lat);
        run(100000, 0, "R6", lat);
        run(297000, 0, "R6", lat);
        run(74250, 0, "R8", lat);
        run(25000, 0, "R3", lat);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule